// File: doc/BRIEF.md
# Memory Cycle Sequencer

This block runs the processor side of one asynchronous memory cycle after another. On a request from the execution unit it captures an address and raises a start pulse toward memory. It then waits for memory to report that the read data is valid. When that report arrives the read word is captured and handed to execution. After a fixed execution interval the block issues a one-cycle write-back pulse. It presents the restore data and keeps it frozen until memory reports the write finished. Each memory decides its own timing, and the block accepts any response delay up to its limits.

Once a write completes, the next cycle starts without a new request if the run input is still high. If run is low at that point the block parks in a halted state until it gets a request with run high. Two give-up counters keep the machine from freezing on an address that no memory answers. One covers the read wait and one covers the write wait. When either expires it supplies a substitute completion and sets a sticky absent-memory flag, and a substituted read delivers an all-zero word.

Top module: `mem_cycle_seq`

## Requirements
- R1: From reset or the halted state, `req` and `run` both high at a clock edge capture `addr_in` onto `mem_addr` and raise `mem_start` for exactly the following cycle; `req` with `run` low starts nothing.
- R2: `mem_strobe` high in any waiting-for-read cycle copies `mem_rdata` into `rd_data` and pulses `rd_valid` for one cycle; a strobe arriving in any other cycle is ignored.
- R3: With no strobe in the first RD_TIMEOUT waiting cycles the read completes anyway, with `rd_data` all zero, a `rd_valid` pulse and `nxm` set; a strobe in exactly the RD_TIMEOUT-th waiting cycle still counts as a real answer.
- R4: Execution lasts EXEC_TICKS cycles after the read completes, after which `mem_wb` is high for exactly one cycle.
- R5: `mem_wdata` takes `wdata_in` at the edge that ends execution and does not change while the block waits for `mem_done`.
- R6: A write completion with `run` high raises `mem_start` in the next cycle with a freshly captured `addr_in`, with no request needed.
- R7: A write completion with `run` low sets `halted`, and the block stays halted with `mem_start` low until it sees `req` and `run` high together.
- R8: With no `mem_done` in the first WR_TIMEOUT waiting cycles the write completes anyway and `nxm` is set; a done on exactly that cycle is a real answer.
- R9: `nxm` stays set once set, until reset.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run flag; low stops the sequencer after the current write |
| req | input | 1 | Start request from the execution unit while idle or halted |
| addr_in | input | ADDR_W | Address for the next cycle |
| wdata_in | input | DATA_W | Restore data from the execution unit |
| mem_start | output | 1 | One-cycle start pulse to memory |
| mem_addr | output | ADDR_W | Address of the current cycle |
| mem_strobe | input | 1 | Read data valid from memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_wb | output | 1 | One-cycle write-back pulse |
| mem_wdata | output | DATA_W | Held write data |
| mem_done | input | 1 | Write finished from memory |
| rd_valid | output | 1 | Read word delivered this cycle |
| rd_data | output | DATA_W | Captured read word |
| halted | output | 1 | Sequencer stopped by a cleared run flag |
| nxm | output | 1 | Sticky flag: a give-up counter supplied a completion |

## Verification
The hard case is a real memory answer and a give-up expiry landing in the same cycle. This happens when the strobe comes on the last allowed read-wait cycle, or the done comes on the last allowed write-wait cycle. The bench provokes this by running a responder whose delays are set to exactly the timeout for a stretch of cycles. The real answer must win: the memory word must be delivered and `nxm` must stay clear. A following stretch uses delays one cycle longer, and there the substitute completion, the zero word and the ignored late pulse must all appear. The behavioural model is compared against the block on every cycle throughout.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_START   = 3'd1,
    S_WAIT_RD = 3'd2,
    S_EXEC    = 3'd3,
    S_WB      = 3'd4,
    S_WAIT_WR = 3'd5,
    S_HALT    = 3'd6
  } seq_state_t;
endpackage

// File: rtl/mcs_giveup_timer.sv
// Counts consecutive armed cycles; hit marks the LIMIT-th armed cycle.
module mcs_giveup_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign hit = arm && (cnt == CW'(LIMIT - 1));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    arm |-> (cnt <= CW'(LIMIT - 1)));
endmodule

// File: rtl/mcs_hold_regs.sv
// Address, write-data and read-data holding registers.
module mcs_hold_regs #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              wd_ld,
  input  logic [DATA_W-1:0] wd_d,
  input  logic              rd_ld,
  input  logic              rd_zero,
  input  logic [DATA_W-1:0] rd_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wd_q,
  output logic [DATA_W-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (addr_ld) addr_q <= addr_d;
      if (wd_ld)   wd_q   <= wd_d;
      if (rd_ld)   rd_q   <= rd_zero ? '0 : rd_d;
    end
  end
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 12,
  parameter int NOMINAL_DLY = 8,
  parameter int RD_TIMEOUT  = 2 * NOMINAL_DLY,
  parameter int WR_TIMEOUT  = 2 * NOMINAL_DLY,
  parameter int EXEC_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              mem_start,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_strobe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wb,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              halted,
  output logic              nxm
);
  localparam int NTMR = 2;  // index 0: read wait, index 1: write wait

  seq_state_t state, nxt;
  logic [NTMR-1:0] tmr_arm, tmr_hit;
  logic exec_hit;
  logic addr_ld, wd_ld, rd_ld, rd_zero, set_nxm;

  // Give-up counters, one per waiting phase.
  for (genvar g = 0; g < NTMR; g++) begin : g_giveup
    localparam int LIM = (g == 0) ? RD_TIMEOUT : WR_TIMEOUT;
    assign tmr_arm[g] = (g == 0) ? (state == S_WAIT_RD) : (state == S_WAIT_WR);
    mcs_giveup_timer #(.LIMIT(LIM)) u_tmr (
      .clk(clk), .rst(rst), .arm(tmr_arm[g]), .hit(tmr_hit[g])
    );
  end

  // Execute interval counter.
  mcs_giveup_timer #(.LIMIT(EXEC_TICKS)) u_exec (
    .clk(clk), .rst(rst), .arm(state == S_EXEC), .hit(exec_hit)
  );

  mcs_hold_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .addr_ld(addr_ld), .addr_d(addr_in),
    .wd_ld(wd_ld), .wd_d(wdata_in),
    .rd_ld(rd_ld), .rd_zero(rd_zero), .rd_d(mem_rdata),
    .addr_q(mem_addr), .wd_q(mem_wdata), .rd_q(rd_data)
  );

  always_comb begin
    nxt     = state;
    addr_ld = 1'b0;
    wd_ld   = 1'b0;
    rd_ld   = 1'b0;
    rd_zero = 1'b0;
    set_nxm = 1'b0;
    unique case (state)
      S_IDLE, S_HALT: begin
        if (req && run) begin
          nxt     = S_START;
          addr_ld = 1'b1;
        end
      end
      S_START: nxt = S_WAIT_RD;
      S_WAIT_RD: begin
        // A real strobe wins over a give-up expiry in the same cycle.
        if (mem_strobe) begin
          nxt   = S_EXEC;
          rd_ld = 1'b1;
        end else if (tmr_hit[0]) begin
          nxt     = S_EXEC;
          rd_ld   = 1'b1;
          rd_zero = 1'b1;
          set_nxm = 1'b1;
        end
      end
      S_EXEC: begin
        if (exec_hit) begin
          nxt   = S_WB;
          wd_ld = 1'b1;
        end
      end
      S_WB: nxt = S_WAIT_WR;
      S_WAIT_WR: begin
        if (mem_done || tmr_hit[1]) begin
          set_nxm = !mem_done;
          if (run) begin
            nxt     = S_START;
            addr_ld = 1'b1;
          end else begin
            nxt = S_HALT;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_start <= 1'b0;
      mem_wb    <= 1'b0;
      halted    <= 1'b0;
      rd_valid  <= 1'b0;
      nxm       <= 1'b0;
    end else begin
      state     <= nxt;
      mem_start <= (nxt == S_START);
      mem_wb    <= (nxt == S_WB);
      halted    <= (nxt == S_HALT);
      rd_valid  <= rd_ld;
      nxm       <= nxm | set_nxm;
    end
  end

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_start |=> !mem_start);

  // R3
  timeout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !$past(mem_strobe)) |-> (rd_data == '0));

  // R4
  wb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wb |=> !mem_wb);

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT_WR) |-> $stable(mem_wdata));

  // R6
  auto_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT_WR && mem_done && run) |=> mem_start);

  // R7
  halt_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !(req && run)) |=> (halted && !mem_start));

  // R9
  nxm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    nxm |=> nxm);
endmodule

// File: tb/tb_mem_cycle_seq.sv
`timescale 1ns/1ps
module tb_mem_cycle_seq;
  localparam int AW = 15;
  localparam int DW = 12;
  localparam int RD_TMO = 16;
  localparam int WR_TMO = 16;
  localparam int EXEC_N = 3;

  localparam int P_IDLE = 0, P_START = 1, P_WRD = 2, P_EXEC = 3,
                 P_WB = 4, P_WWR = 5, P_HALT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0, req = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wdata_in = '0;
  logic mem_strobe = 1'b0, mem_done = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_start, mem_wb, rd_valid, halted, nxm;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rd_data;

  always #2.5 clk = ~clk;

  mem_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .NOMINAL_DLY(8),
                  .RD_TIMEOUT(RD_TMO), .WR_TIMEOUT(WR_TMO),
                  .EXEC_TICKS(EXEC_N)) dut (
    .clk(clk), .rst(rst), .run(run), .req(req), .addr_in(addr_in),
    .wdata_in(wdata_in), .mem_start(mem_start), .mem_addr(mem_addr),
    .mem_strobe(mem_strobe), .mem_rdata(mem_rdata), .mem_wb(mem_wb),
    .mem_wdata(mem_wdata), .mem_done(mem_done), .rd_valid(rd_valid),
    .rd_data(rd_data), .halted(halted), .nxm(nxm)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge.
  int ph = P_IDLE, wcnt = 0, ecnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  logic m_rv = 0, m_nxm = 0, m_start = 0, m_wb = 0, m_halt = 0;

  always @(posedge clk) begin
    m_rv = 1'b0;
    if (rst) begin
      ph = P_IDLE; wcnt = 0; ecnt = 0;
      m_addr = '0; m_wd = '0; m_rd = '0; m_nxm = 1'b0;
    end else begin
      case (ph)
        P_IDLE, P_HALT:
          if (req && run) begin ph = P_START; m_addr = addr_in; end
        P_START: begin ph = P_WRD; wcnt = 0; end
        P_WRD: begin
          wcnt++;
          if (mem_strobe) begin
            m_rd = mem_rdata; m_rv = 1'b1; ph = P_EXEC; ecnt = 0;
          end else if (wcnt == RD_TMO) begin
            m_rd = '0; m_rv = 1'b1; m_nxm = 1'b1; ph = P_EXEC; ecnt = 0;
          end
        end
        P_EXEC: begin
          ecnt++;
          if (ecnt == EXEC_N) begin ph = P_WB; m_wd = wdata_in; end
        end
        P_WB: begin ph = P_WWR; wcnt = 0; end
        P_WWR: begin
          wcnt++;
          if (mem_done || wcnt == WR_TMO) begin
            if (!mem_done) m_nxm = 1'b1;
            if (run) begin ph = P_START; m_addr = addr_in; end
            else ph = P_HALT;
          end
        end
        default: ph = P_IDLE;
      endcase
    end
    m_start = (ph == P_START);
    m_wb    = (ph == P_WB);
    m_halt  = (ph == P_HALT);
  end

  // Responder state.
  logic [DW-1:0] bank [0:63];
  int mode = 0;          // 0 random delay, 1 exactly timeout, 2 timeout+1
  bit absent_sel = 0;    // drive addresses that no memory answers
  bit rd_pend = 0, wr_pend = 0;
  int rcnt = 0, dcnt = 0;
  logic [AW-1:0] raddr = '0, waddr = '0;
  int cyc = 0;

  function automatic int pick(input int tmo);
    if (mode == 0) return int'($urandom_range(1, tmo));
    else if (mode == 1) return tmo;
    else return tmo + 1;
  endfunction

  function automatic bit present(input logic [AW-1:0] a);
    return a < AW'(64);
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    chk("R1 R6", "mem_start", 32'(mem_start), 32'(m_start));
    chk("R1", "mem_addr", 32'(mem_addr), 32'(m_addr));
    chk("R2", "rd_valid", 32'(rd_valid), 32'(m_rv));
    chk("R2 R3", "rd_data", 32'(rd_data), 32'(m_rd));
    chk("R4", "mem_wb", 32'(mem_wb), 32'(m_wb));
    chk("R5", "mem_wdata", 32'(mem_wdata), 32'(m_wd));
    chk("R7", "halted", 32'(halted), 32'(m_halt));
    chk("R8 R9", "nxm", 32'(nxm), 32'(m_nxm));
    mem_strobe = 1'b0;
    mem_done   = 1'b0;
    mem_rdata  = DW'($urandom);
    if (rd_pend) begin
      rcnt--;
      if (rcnt == 0) begin
        mem_strobe = 1'b1; mem_rdata = bank[raddr[5:0]]; rd_pend = 0;
      end
    end
    if (wr_pend) begin
      dcnt--;
      if (dcnt == 0) begin
        mem_done = 1'b1; bank[waddr[5:0]] = mem_wdata; wr_pend = 0;
      end
    end
    if (mem_start && present(mem_addr)) begin
      rd_pend = 1; rcnt = pick(RD_TMO); raddr = mem_addr;
    end
    if (mem_wb && present(mem_addr)) begin
      wr_pend = 1; dcnt = pick(WR_TMO); waddr = mem_addr;
    end
    wdata_in = DW'($urandom);
    addr_in  = absent_sel ? (AW'(16'h4000) | AW'($urandom_range(0, 255)))
                          : AW'($urandom_range(0, 63));
  endtask

  task automatic do_reset();
    rst = 1'b1; rd_pend = 0; wr_pend = 0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) bank[i] = DW'(i * 37 + 5);
    do_reset();
    tick();
    // R10: everything low after reset
    chk("R10", "reset mem_start", 32'(mem_start), 0);
    chk("R10", "reset halted", 32'(halted), 0);
    chk("R10", "reset nxm", 32'(nxm), 0);
    chk("R10", "reset rd_data", 32'(rd_data), 0);
    chk("R10", "reset mem_wdata", 32'(mem_wdata), 0);

    // R1: request without run starts nothing
    req = 1'b1; repeat (4) tick(); req = 1'b0;
    chk("R1", "no start without run", 32'(mem_start), 0);

    // R2 R4 R5 R6: random delays below the limits, auto restart
    run = 1'b1; mode = 0; req = 1'b1; tick(); req = 1'b0;
    repeat (600) tick();
    chk("R2", "no give-up with timely memory", 32'(nxm), 0);

    // R3 R8 boundary: answers on the last allowed cycle are real
    mode = 1; repeat (400) tick();
    chk("R3", "strobe on limit accepted", 32'(nxm), 0);

    // R3 R8: answers one cycle late are ignored; substitutes used
    mode = 2; repeat (300) tick();
    chk("R3", "late answer gives nxm", 32'(nxm), 1);

    // R9: reset clears the sticky flag
    run = 1'b0; do_reset(); tick();
    chk("R9", "nxm cleared by reset", 32'(nxm), 0);

    // R8: absent memory, both waits give up
    mode = 0; absent_sel = 1; run = 1'b1; req = 1'b1; tick(); req = 1'b0;
    repeat (200) tick();
    chk("R8", "absent memory sets nxm", 32'(nxm), 1);
    chk("R3", "absent read word zero", 32'(rd_data), 0);

    // R9: flag stays through later good cycles
    absent_sel = 0; repeat (300) tick();
    chk("R9", "nxm sticky", 32'(nxm), 1);

    // R7: clear run, sequencer halts and stays halted
    run = 1'b0; repeat (120) tick();
    chk("R7", "halted after run cleared", 32'(halted), 1);
    req = 1'b1; repeat (5) tick(); req = 1'b0;
    chk("R7", "req without run keeps halt", 32'(halted), 1);

    // R1: restart from halt
    run = 1'b1; req = 1'b1; tick(); req = 1'b0;
    chk("R1", "restart from halt", 32'(mem_start), 1);
    repeat (300) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule